// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block arbitrates a parameterised set of interrupt request lines (64 by default) on behalf of a processor core. Software gives each source a 2-bit level through a small slave register bus. Level 0 turns a source off. Arbitration has two stages. Within each non-zero level, the active source with the lowest number is chosen. Across levels, the highest level that has an active request wins. The core sees an interrupt only when that winning level is above its current priority mask.

For a winning source, the vector address is a programmable base plus twice the source number. Two fast-interrupt slots can each claim one source. When the winner matches an enabled slot, that slot's own vector address replaces the computed one. A combinational wake output tells the clock controller to restart clocks while the core sits in a low-power mode. Whenever no interrupt is being raised, including right after reset, the vector output carries a fixed reset address.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `irq_out`, `irq_lvl`, `irq_src` and `fast_hit` are 0, `irq_vec` equals the `RESET_VEC` parameter (default 16'h0100), and every level field reads 0 except those of fixed-priority sources.
- R2: Level register at address k (k = 0..7) holds sources 8k..8k+7. Source 8k+j has its level in bits [2j+1:2j]. Writes occur when `bus_wr` is high at a clock edge, and `bus_rdata` returns the fields combinationally.
- R3: Sources marked in `FIXED_SRC` (default sources 0 and 1) always have level `FIXED_LVL` (default 3). Writes to their fields are ignored, and the fields read back as the fixed level.
- R4: A source at level 0 never raises an interrupt.
- R5: Among active sources sharing one level, the lowest-numbered source wins.
- R6: An active source at a higher level wins over any active source at a lower level, whatever their numbers.
- R7: `irq_out` is raised only when the winning level is strictly greater than `core_mask`.
- R8: The vector is the base register (address 8) plus 2 × the winning source number.
- R9: Fast slot k (k = 0, 1) has a select register at address 9+2k and a vector register at address 10+2k. In the select register, bit 15 is the enable and bits [5:0] are the source. If the winner matches an enabled slot, `irq_vec` is that slot's vector and `fast_hit` is 1. Slot 0 takes precedence over slot 1.
- R10: `irq_out`, `irq_lvl`, `irq_src`, `irq_vec` and `fast_hit` are registered. They reflect the requests and `core_mask` sampled at the previous clock edge.
- R11: `wake_req` is high, with no clock delay, exactly when `low_power` is high and some active request has a non-zero level.
- R12: While `irq_out` is low, `irq_vec` equals `RESET_VEC` and `irq_src`, `irq_lvl` and `fast_hit` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Register read data (combinational) |
| irq_req | input | NUM_SRC | Interrupt request lines, bit i is source i |
| core_mask | input | LVL_W | Current core priority mask |
| low_power | input | 1 | Core is in a wait or stop mode |
| irq_out | output | 1 | Interrupt request to the core |
| irq_lvl | output | LVL_W | Level of the raised interrupt |
| irq_src | output | log2(NUM_SRC) | Number of the raised source |
| irq_vec | output | DATA_W | Vector address |
| fast_hit | output | 1 | Raised source is served by a fast slot |
| wake_req | output | 1 | Clock restart request |

## Verification
The arbitration outputs are due one clock edge after the requests, the mask or a register write settle. The bench drives every input on the falling edge and samples on a later falling edge. It also checks, just after driving a new request, that the registered outputs still hold their old values before the next rising edge. Register read data and `wake_req` are combinational, so they are sampled a short delay after the driving edge, in the same cycle.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
   // number of fast-interrupt slots
   localparam int NUM_FAST = 2;

   // address of the vector base register, given the number of level registers
   function automatic int base_ofs(input int nlreg);
      return nlreg;
   endfunction

   // address of the select register of fast slot k
   function automatic int fsel_ofs(input int nlreg, input int k);
      return nlreg + 1 + 2 * k;
   endfunction

   // address of the vector register of fast slot k
   function automatic int fvec_ofs(input int nlreg, input int k);
      return nlreg + 2 + 2 * k;
   endfunction
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
   import irq_ctrl_pkg::*;
#(
   parameter int NUM_SRC = 64,
   parameter int LVL_W = 2,
   parameter int DATA_W = 16,
   parameter int ADDR_W = 4,
   parameter logic [NUM_SRC-1:0] FIXED_SRC = '0,
   parameter logic [LVL_W-1:0] FIXED_LVL = '1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [NUM_SRC-1:0][LVL_W-1:0] src_lvl,
   output logic [DATA_W-1:0] vec_base,
   output logic [NUM_FAST-1:0] fast_en,
   output logic [NUM_FAST-1:0][$clog2(NUM_SRC)-1:0] fast_sel,
   output logic [NUM_FAST-1:0][DATA_W-1:0] fast_vec
);
   localparam int SRC_W = $clog2(NUM_SRC);
   localparam int PER_REG = DATA_W / LVL_W;
   localparam int NUM_LREG = NUM_SRC / PER_REG;

   logic [NUM_SRC-1:0][LVL_W-1:0] lvl_q;
   logic [DATA_W-1:0] base_q;
   logic [NUM_FAST-1:0] en_q;
   logic [NUM_FAST-1:0][SRC_W-1:0] sel_q;
   logic [NUM_FAST-1:0][DATA_W-1:0] fvec_q;

   // level fields; fixed sources are held at their constant level
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_SRC; i++)
            lvl_q[i] <= FIXED_SRC[i] ? FIXED_LVL : '0;
      end else if (bus_wr) begin
         for (int i = 0; i < NUM_SRC; i++) begin
            if (bus_addr == ADDR_W'(i / PER_REG))
               lvl_q[i] <= FIXED_SRC[i] ? FIXED_LVL
                                        : bus_wdata[(i % PER_REG) * LVL_W +: LVL_W];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         base_q <= '0;
      else if (bus_wr && bus_addr == ADDR_W'(base_ofs(NUM_LREG)))
         base_q <= bus_wdata;
   end

   // one register pair per fast slot
   for (genvar k = 0; k < NUM_FAST; k++) begin : g_fast
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            en_q[k]   <= 1'b0;
            sel_q[k]  <= '0;
            fvec_q[k] <= '0;
         end else if (bus_wr) begin
            if (bus_addr == ADDR_W'(fsel_ofs(NUM_LREG, k))) begin
               en_q[k]  <= bus_wdata[DATA_W-1];
               sel_q[k] <= bus_wdata[SRC_W-1:0];
            end
            if (bus_addr == ADDR_W'(fvec_ofs(NUM_LREG, k)))
               fvec_q[k] <= bus_wdata;
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (bus_addr == ADDR_W'(i / PER_REG))
            bus_rdata[(i % PER_REG) * LVL_W +: LVL_W] = lvl_q[i];
      end
      if (bus_addr == ADDR_W'(base_ofs(NUM_LREG)))
         bus_rdata = base_q;
      for (int k = 0; k < NUM_FAST; k++) begin
         if (bus_addr == ADDR_W'(fsel_ofs(NUM_LREG, k))) begin
            bus_rdata = '0;
            bus_rdata[DATA_W-1] = en_q[k];
            bus_rdata[SRC_W-1:0] = sel_q[k];
         end
         if (bus_addr == ADDR_W'(fvec_ofs(NUM_LREG, k)))
            bus_rdata = fvec_q[k];
      end
   end

   assign src_lvl  = lvl_q;
   assign vec_base = base_q;
   assign fast_en  = en_q;
   assign fast_sel = sel_q;
   assign fast_vec = fvec_q;
endmodule

// File: rtl/irq_level_enc.sv
module irq_level_enc #(
   parameter int NUM_SRC = 64,
   parameter int LVL_W = 2
) (
   input  logic [NUM_SRC-1:0] irq_req,
   input  logic [NUM_SRC-1:0][LVL_W-1:0] src_lvl,
   output logic any_en,
   output logic [LVL_W-1:0] win_lvl,
   output logic [$clog2(NUM_SRC)-1:0] win_src
);
   localparam int SRC_W = $clog2(NUM_SRC);
   localparam int NUM_LVL = 1 << LVL_W;

   logic [NUM_LVL-1:0] lvl_found;
   logic [NUM_LVL-1:0][SRC_W-1:0] lvl_idx;
   logic [NUM_SRC-1:0] en_vec;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_en
      assign en_vec[i] = irq_req[i] && (src_lvl[i] != '0);
   end
   assign any_en = |en_vec;

   // one lowest-number-first encoder per level; level 0 is disabled
   for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
      if (l == 0) begin : g_off
         assign lvl_found[l] = 1'b0;
         assign lvl_idx[l]   = '0;
      end else begin : g_on
         always_comb begin
            lvl_found[l] = 1'b0;
            lvl_idx[l]   = '0;
            for (int i = NUM_SRC - 1; i >= 0; i--) begin
               if (irq_req[i] && src_lvl[i] == LVL_W'(l)) begin
                  lvl_found[l] = 1'b1;
                  lvl_idx[l]   = SRC_W'(i);
               end
            end
         end
      end
   end

   // highest non-empty level takes the win
   always_comb begin
      win_lvl = '0;
      win_src = '0;
      for (int l = 1; l < NUM_LVL; l++) begin
         if (lvl_found[l]) begin
            win_lvl = LVL_W'(l);
            win_src = lvl_idx[l];
         end
      end
   end
endmodule

// File: rtl/irq_vec_gen.sv
module irq_vec_gen
   import irq_ctrl_pkg::*;
#(
   parameter int NUM_SRC = 64,
   parameter int LVL_W = 2,
   parameter int DATA_W = 16,
   parameter logic [DATA_W-1:0] RESET_VEC = '0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic [LVL_W-1:0] win_lvl,
   input  logic [$clog2(NUM_SRC)-1:0] win_src,
   input  logic [LVL_W-1:0] core_mask,
   input  logic [DATA_W-1:0] vec_base,
   input  logic [NUM_FAST-1:0] fast_en,
   input  logic [NUM_FAST-1:0][$clog2(NUM_SRC)-1:0] fast_sel,
   input  logic [NUM_FAST-1:0][DATA_W-1:0] fast_vec,
   output logic irq_out,
   output logic [LVL_W-1:0] irq_lvl,
   output logic [$clog2(NUM_SRC)-1:0] irq_src,
   output logic [DATA_W-1:0] irq_vec,
   output logic fast_hit
);
   localparam int SRC_W = $clog2(NUM_SRC);

   logic raise;
   logic [NUM_FAST-1:0] slot_match;
   logic hit_d;
   logic [DATA_W-1:0] vec_d;

   assign raise = win_lvl > core_mask;

   for (genvar k = 0; k < NUM_FAST; k++) begin : g_match
      assign slot_match[k] = fast_en[k] && (fast_sel[k] == win_src);
   end

   always_comb begin
      hit_d = 1'b0;
      vec_d = vec_base + {{(DATA_W-SRC_W-1){1'b0}}, win_src, 1'b0};
      for (int k = NUM_FAST - 1; k >= 0; k--) begin
         if (slot_match[k]) begin
            hit_d = 1'b1;
            vec_d = fast_vec[k];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_out  <= 1'b0;
         irq_lvl  <= '0;
         irq_src  <= '0;
         irq_vec  <= RESET_VEC;
         fast_hit <= 1'b0;
      end else if (raise) begin
         irq_out  <= 1'b1;
         irq_lvl  <= win_lvl;
         irq_src  <= win_src;
         irq_vec  <= vec_d;
         fast_hit <= hit_d;
      end else begin
         irq_out  <= 1'b0;
         irq_lvl  <= '0;
         irq_src  <= '0;
         irq_vec  <= RESET_VEC;
         fast_hit <= 1'b0;
      end
   end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import irq_ctrl_pkg::*;
#(
   parameter int NUM_SRC = 64,
   parameter int LVL_W = 2,
   parameter int DATA_W = 16,
   parameter int ADDR_W = 4,
   parameter logic [NUM_SRC-1:0] FIXED_SRC = NUM_SRC'(3),
   parameter logic [LVL_W-1:0] FIXED_LVL = '1,
   parameter logic [DATA_W-1:0] RESET_VEC = DATA_W'(16'h0100)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NUM_SRC-1:0] irq_req,
   input  logic [LVL_W-1:0] core_mask,
   input  logic low_power,
   output logic irq_out,
   output logic [LVL_W-1:0] irq_lvl,
   output logic [$clog2(NUM_SRC)-1:0] irq_src,
   output logic [DATA_W-1:0] irq_vec,
   output logic fast_hit,
   output logic wake_req
);
   localparam int SRC_W = $clog2(NUM_SRC);
   localparam int PER_REG = DATA_W / LVL_W;
   localparam int NUM_LREG = NUM_SRC / PER_REG;

   // elaboration-time parameter checks
   if (DATA_W % LVL_W != 0) begin : g_chk_pack
      $error("DATA_W must be a multiple of LVL_W");
   end
   if (NUM_SRC % PER_REG != 0) begin : g_chk_src
      $error("NUM_SRC must fill whole level registers");
   end
   if ((1 << ADDR_W) < fvec_ofs(NUM_LREG, NUM_FAST - 1) + 1) begin : g_chk_addr
      $error("ADDR_W too small for the register map");
   end
   if (DATA_W < SRC_W + 2) begin : g_chk_vec
      $error("DATA_W too small for vector and select fields");
   end

   logic [NUM_SRC-1:0][LVL_W-1:0] src_lvl;
   logic [DATA_W-1:0] vec_base;
   logic [NUM_FAST-1:0] fast_en;
   logic [NUM_FAST-1:0][SRC_W-1:0] fast_sel;
   logic [NUM_FAST-1:0][DATA_W-1:0] fast_vec;
   logic any_en;
   logic [LVL_W-1:0] win_lvl;
   logic [SRC_W-1:0] win_src;

   irq_cfg_regs #(
      .NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
      .FIXED_SRC(FIXED_SRC), .FIXED_LVL(FIXED_LVL)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_lvl(src_lvl),
      .vec_base(vec_base), .fast_en(fast_en), .fast_sel(fast_sel),
      .fast_vec(fast_vec)
   );

   irq_level_enc #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_enc (
      .irq_req(irq_req), .src_lvl(src_lvl), .any_en(any_en),
      .win_lvl(win_lvl), .win_src(win_src)
   );

   irq_vec_gen #(
      .NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .DATA_W(DATA_W), .RESET_VEC(RESET_VEC)
   ) u_vec (
      .clk(clk), .rst_n(rst_n), .win_lvl(win_lvl), .win_src(win_src),
      .core_mask(core_mask), .vec_base(vec_base), .fast_en(fast_en),
      .fast_sel(fast_sel), .fast_vec(fast_vec), .irq_out(irq_out),
      .irq_lvl(irq_lvl), .irq_src(irq_src), .irq_vec(irq_vec),
      .fast_hit(fast_hit)
   );

   // wake path is combinational so it works with clocks stopped
   assign wake_req = low_power && any_en;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
   parameter int NUM_SRC = 64,
   parameter int LVL_W = 2,
   parameter int DATA_W = 16,
   parameter logic [DATA_W-1:0] RESET_VEC = '0
) (
   input logic clk,
   input logic rst_n,
   input logic [NUM_SRC-1:0] irq_req,
   input logic [LVL_W-1:0] core_mask,
   input logic low_power,
   input logic irq_out,
   input logic [LVL_W-1:0] irq_lvl,
   input logic [$clog2(NUM_SRC)-1:0] irq_src,
   input logic [DATA_W-1:0] irq_vec,
   input logic fast_hit,
   input logic wake_req
);
   logic [NUM_SRC-1:0] req_d;
   logic [LVL_W-1:0] mask_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_d  <= '0;
         mask_d <= '0;
      end else begin
         req_d  <= irq_req;
         mask_d <= core_mask;
      end
   end

   // R7
   mask_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (irq_lvl > mask_d));

   // R10
   src_was_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> req_d[irq_src]);

   // R4
   lvl_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (irq_lvl != '0));

   // R12
   idle_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_out |-> (irq_vec == RESET_VEC && irq_src == '0 && !fast_hit));

   // R9
   fast_raised_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fast_hit |-> irq_out);

   // R11
   wake_lp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |-> low_power);
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(
   .NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .DATA_W(DATA_W), .RESET_VEC(RESET_VEC)
) u_chk (
   .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .core_mask(core_mask),
   .low_power(low_power), .irq_out(irq_out), .irq_lvl(irq_lvl),
   .irq_src(irq_src), .irq_vec(irq_vec), .fast_hit(fast_hit),
   .wake_req(wake_req)
);

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
   localparam int CLK_P = 10;
   localparam logic [15:0] RVEC = 16'h0100;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_wr = 1'b0;
   logic [3:0] bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [63:0] irq_req = '0;
   logic [1:0] core_mask = '0;
   logic low_power = 1'b0;
   logic irq_out;
   logic [1:0] irq_lvl;
   logic [5:0] irq_src;
   logic [15:0] irq_vec;
   logic fast_hit;
   logic wake_req;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_P / 2) clk = ~clk;

   prio_irq_ctrl u_prio_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req),
      .core_mask(core_mask), .low_power(low_power), .irq_out(irq_out),
      .irq_lvl(irq_lvl), .irq_src(irq_src), .irq_vec(irq_vec),
      .fast_hit(fast_hit), .wake_req(wake_req)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [15:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   // set requests, let one rising edge register them, sample at falling edge
   task automatic drive(input logic [63:0] r, input logic [1:0] m);
      @(negedge clk);
      irq_req = r; core_mask = m;
      @(negedge clk);
   endtask

   task automatic t_reset();
      logic [15:0] d;
      check("R1", "irq_out", 32'(irq_out), 0);
      check("R1", "irq_vec", 32'(irq_vec), 32'(RVEC));
      check("R1", "fast_hit", 32'(fast_hit), 0);
      rd(4'd0, d); check("R1", "lvl reg0", 32'(d), 32'h000F);
      rd(4'd5, d); check("R1", "lvl reg5", 32'(d), 0);
   endtask

   task automatic t_regmap();
      logic [15:0] d;
      // src16=0, src17=1, src18=2, src19=1
      wr(4'd2, 16'h0064);
      rd(4'd2, d); check("R2", "lvl reg2 readback", 32'(d), 32'h0064);
   endtask

   task automatic t_fixed();
      logic [15:0] d;
      wr(4'd0, 16'h0050);
      rd(4'd0, d); check("R3", "fixed fields kept", 32'(d), 32'h005F);
   endtask

   task automatic t_disable();
      drive(64'h1 << 20, 2'd0);
      check("R4", "lvl0 src no irq", 32'(irq_out), 0);
      check("R12", "idle vec", 32'(irq_vec), 32'(RVEC));
      check("R12", "idle src", 32'(irq_src), 0);
   endtask

   task automatic t_lowest();
      wr(4'd8, 16'h2000);
      drive((64'h1 << 17) | (64'h1 << 19), 2'd0);
      check("R5", "lowest wins src", 32'(irq_src), 17);
      check("R8", "vector base+2n", 32'(irq_vec), 32'h2022);
      check("R5", "irq_lvl", 32'(irq_lvl), 1);
   endtask

   task automatic t_levels();
      drive((64'h1 << 18) | (64'h1 << 19) | (64'h1 << 17), 2'd0);
      check("R6", "higher level wins", 32'(irq_src), 18);
      check("R6", "level", 32'(irq_lvl), 2);
      check("R8", "vector", 32'(irq_vec), 32'h2024);
   endtask

   task automatic t_mask();
      drive(64'h1 << 18, 2'd2);
      check("R7", "mask equal blocks", 32'(irq_out), 0);
      drive(64'h1 << 18, 2'd1);
      check("R7", "mask below raises", 32'(irq_out), 1);
      drive(64'h1, 2'd3);
      check("R7", "mask 3 blocks all", 32'(irq_out), 0);
      drive(64'h1, 2'd2);
      check("R7", "fixed src0 raises", 32'(irq_src), 0);
      check("R8", "src0 vector", 32'(irq_vec), 32'h2000);
   endtask

   task automatic t_latency();
      drive('0, 2'd0);
      @(negedge clk);
      irq_req = 64'h1 << 19;
      #1 check("R10", "not before edge", 32'(irq_out), 0);
      @(posedge clk);
      #1 check("R10", "after one edge", 32'(irq_out), 1);
      check("R10", "src after one edge", 32'(irq_src), 19);
   endtask

   task automatic t_fast();
      logic [15:0] d;
      wr(4'd9, 16'h8013);
      wr(4'd10, 16'h3000);
      rd(4'd9, d); check("R9", "sel0 readback", 32'(d), 32'h8013);
      drive(64'h1 << 19, 2'd0);
      check("R9", "slot0 vector", 32'(irq_vec), 32'h3000);
      check("R9", "fast_hit", 32'(fast_hit), 1);
      wr(4'd11, 16'h8013);
      wr(4'd12, 16'h4000);
      drive(64'h1 << 19, 2'd0);
      check("R9", "slot0 over slot1", 32'(irq_vec), 32'h3000);
      wr(4'd9, 16'h0013);
      drive(64'h1 << 19, 2'd0);
      check("R9", "slot1 when slot0 off", 32'(irq_vec), 32'h4000);
      drive(64'h1 << 17, 2'd0);
      check("R9", "no match normal vec", 32'(irq_vec), 32'h2022);
      check("R9", "no match no hit", 32'(fast_hit), 0);
   endtask

   task automatic t_wake();
      @(negedge clk);
      irq_req = 64'h1 << 20; low_power = 1'b1; core_mask = 2'd3;
      #1 check("R11", "lvl0 no wake", 32'(wake_req), 0);
      irq_req = 64'h1 << 17;
      #1 check("R11", "wake immediate", 32'(wake_req), 1);
      low_power = 1'b0;
      #1 check("R11", "no wake when awake", 32'(wake_req), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regmap();
      t_fixed();
      t_disable();
      t_lowest();
      t_levels();
      t_mask();
      t_latency();
      t_fast();
      t_wake();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #(CLK_P * 100000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule